// File: doc/BRIEF.md
# Control Endpoint Transfer Sequencer

This block steps the zero-numbered control endpoint of a USB device controller through the stages of a control transfer. On the bus side it sees decoded events: a token kind with the byte count of the data packet that followed it, a direction bit taken from the setup payload, and an acknowledge from the host after an IN data packet. On the firmware side it takes single-cycle command strobes and shows sticky status flags, an endpoint state code and one level interrupt.

For every token it chooses the handshake the device returns: ACK, NAK, STALL, a data packet, or nothing. It applies the stage rules itself. Setup payloads must be exactly eight bytes. Data-stage OUT packets may not exceed the maximum packet size. Once firmware has closed the data stage, further data in the same direction is stalled, and the status packet must be empty. A token of the wrong direction in mid-transfer aborts back to idle with a setup-end flag. Firmware can also request a stall, which is returned to the next host request. Bit serialisation and the packet buffer are handled elsewhere.

Top module: `usb_ctl_ep_seq`

## Requirements
- R1: After reset, ep_state is IDLE (0), hs_code is none (0), and out_rdy, in_rdy, in_sent, sent_stall, setup_end, data_end and irq are all 0.
- R2: A setup event (txn_tok 0) of exactly 8 bytes is answered with ACK (hs_code 1) and sets out_rdy. A setup event of any other length gets hs_code 0 and changes nothing.
- R3: When out_rdy is set after a setup in IDLE, fw_clr_rdy with data_end 0 (and fw_data_end 0) clears out_rdy and moves to TX (1) if setup_dir_in was 1, otherwise to RX (2). With data_end or fw_data_end at 1, the state stays IDLE and a status stage is expected.
- R4: In TX, an IN token (txn_tok 1) gets a data packet (hs_code 4) when in_rdy is set, and NAK (hs_code 2) when it is not. host_ack after that data packet clears in_rdy and sets in_sent. If data_end was set, host_ack also returns the state to IDLE.
- R5: In RX, an OUT token (txn_tok 2) of at most MAX_PKT bytes gets ACK and sets out_rdy. A longer packet gets STALL (hs_code 3) and sets sent_stall. An OUT token that arrives while out_rdy is still set gets NAK.
- R6: After an IN data stage is closed, an IN token or a non-empty OUT status packet gets STALL, and an empty OUT gets ACK. After an OUT stage or a no-data setup is closed, an OUT token gets STALL and IN gets a zero-length data packet. Completing the status stage clears data_end. In IDLE with no status stage pending, IN and OUT get NAK.
- R7: After fw_send_stall, the next IN or OUT token gets STALL, sets sent_stall and returns the state to IDLE.
- R8: An OUT token in TX, or an IN token in RX, sets setup_end and forces IDLE with no handshake. setup_end stays set until fw_clr_setup_end.
- R9: fw_clr_stall clears sent_stall, returns the state to IDLE, and cancels a pending fw_send_stall request. A following token then gets its normal response.
- R10: A valid 8-byte setup is accepted in any state, even with a stall request pending. It forces IDLE, and it also sets setup_end when the state was TX or RX.
- R11: irq is 1 exactly when irq_en is 1 and at least one of out_rdy, in_sent, sent_stall or setup_end is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_en | input | 1 | Interrupt enable |
| txn_valid | input | 1 | One-cycle strobe: a decoded token with its data packet |
| txn_tok | input | 2 | Token kind: 0 setup, 1 IN, 2 OUT |
| txn_len | input | LEN_W | Byte count of the data packet that followed the token |
| setup_dir_in | input | 1 | Direction from the setup payload, 1 = device to host |
| host_ack | input | 1 | Host acknowledged the last IN data packet |
| fw_clr_rdy | input | 1 | Firmware: received packet unloaded |
| fw_data_end | input | 1 | Firmware: the current data stage ends |
| fw_in_rdy | input | 1 | Firmware: an IN packet is loaded |
| fw_send_stall | input | 1 | Firmware: stall the next request |
| fw_clr_stall | input | 1 | Firmware: clear sent_stall |
| fw_clr_setup_end | input | 1 | Firmware: clear setup_end |
| fw_clr_in_sent | input | 1 | Firmware: clear in_sent |
| hs_code | output | 3 | Response, one cycle after txn_valid: 0 none, 1 ACK, 2 NAK, 3 STALL, 4 data |
| ep_state | output | 2 | 0 IDLE, 1 TX, 2 RX |
| out_rdy | output | 1 | Received packet waiting for firmware |
| in_rdy | output | 1 | IN packet loaded and not yet acknowledged |
| in_sent | output | 1 | An IN packet was acknowledged |
| sent_stall | output | 1 | A STALL was returned |
| setup_end | output | 1 | Transfer aborted by an unexpected token or a new setup |
| data_end | output | 1 | Data stage closed, status stage pending |
| irq | output | 1 | Endpoint interrupt, level |

## Verification
Directed transfers cover the three shapes of a control transfer: IN data, OUT data and no data. Each shape is closed both correctly and with a protocol violation, so a swapped status direction shows up as an ACK where a STALL belongs. Misplaced tokens, a stall request, a stall request that is then cancelled, and a setup arriving mid-transfer each leave their own flag pattern. Random setup lengths separate the exact-eight check from a range check. Random OUT lengths around the 32-byte limit expose off-by-one errors in the size comparison.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

  typedef enum logic [1:0] {
    EP_IDLE = 2'd0,
    EP_TX   = 2'd1,
    EP_RX   = 2'd2
  } ep_state_e;

  localparam logic [1:0] TK_SETUP = 2'd0;
  localparam logic [1:0] TK_IN    = 2'd1;
  localparam logic [1:0] TK_OUT   = 2'd2;

  typedef enum logic [2:0] {
    HS_NONE  = 3'd0,
    HS_ACK   = 3'd1,
    HS_NAK   = 3'd2,
    HS_STALL = 3'd3,
    HS_DATA  = 3'd4
  } hs_e;

  // sticky flag slots
  localparam int NFLAG = 4;
  localparam int F_OUT = 0;
  localparam int F_INS = 1;
  localparam int F_STL = 2;
  localparam int F_SUE = 3;

  typedef struct packed {
    ep_state_e st;
    logic      swait;    // status stage pending
    logic      stat_in;  // status expects an IN token
    logic      dir_in;   // direction from the last setup
    logic      in_rdy;
    logic      in_pend;  // data packet sent, awaiting host ack
    logic      dend;
    logic      sreq;     // firmware stall request
  } ctx_t;

endpackage

// File: rtl/ep0_flag.sv
module ep0_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic en;
  assign en = set | clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= set;
  end
endmodule

// File: rtl/ep0_decide.sv
module ep0_decide
  import ep0_pkg::*;
#(
  parameter int LEN_W     = 7,
  parameter int SETUP_LEN = 8,
  parameter int MAX_PKT   = 32
) (
  input  ctx_t             cur,
  input  logic [NFLAG-1:0] flg,
  input  logic             txn_valid,
  input  logic [1:0]       txn_tok,
  input  logic [LEN_W-1:0] txn_len,
  input  logic             setup_dir_in,
  input  logic             host_ack,
  input  logic             fw_clr_rdy,
  input  logic             fw_data_end,
  input  logic             fw_in_rdy,
  input  logic             fw_send_stall,
  input  logic             fw_clr_stall,
  input  logic             fw_clr_setup_end,
  input  logic             fw_clr_in_sent,
  output ctx_t             nxt,
  output logic [NFLAG-1:0] fset,
  output logic [NFLAG-1:0] fclr,
  output hs_e              hs
);
  localparam logic [LEN_W-1:0] L_SETUP = LEN_W'(SETUP_LEN);
  localparam logic [LEN_W-1:0] L_MAX   = LEN_W'(MAX_PKT);

  function automatic ctx_t to_idle(input ctx_t c);
    ctx_t r;
    r         = c;
    r.st      = EP_IDLE;
    r.swait   = 1'b0;
    r.dend    = 1'b0;
    r.in_rdy  = 1'b0;
    r.in_pend = 1'b0;
    r.sreq    = 1'b0;
    return r;
  endfunction

  logic do_stall;
  logic do_abort;
  logic de_eff;
  logic is_in;
  logic is_out;

  assign de_eff = cur.dend | fw_data_end;
  assign is_in  = (txn_tok == TK_IN);
  assign is_out = (txn_tok == TK_OUT);

  always_comb begin
    nxt      = cur;
    fset     = '0;
    fclr     = '0;
    hs       = HS_NONE;
    do_stall = 1'b0;
    do_abort = 1'b0;

    if (txn_valid) begin
      if (txn_tok == TK_SETUP) begin
        if (txn_len == L_SETUP) begin
          hs          = HS_ACK;
          fset[F_OUT] = 1'b1;
          fclr[F_INS] = 1'b1;
          if (cur.st != EP_IDLE) fset[F_SUE] = 1'b1;
          nxt         = to_idle(cur);
          nxt.dir_in  = setup_dir_in;
        end
      end else if (cur.sreq) begin
        do_stall = 1'b1;
      end else begin
        case (cur.st)
          EP_TX: begin
            if (is_in) begin
              if (cur.in_rdy && !cur.in_pend) begin
                hs          = HS_DATA;
                nxt.in_pend = 1'b1;
              end else begin
                hs = HS_NAK;
              end
            end else begin
              do_abort = 1'b1;
            end
          end
          EP_RX: begin
            if (is_out) begin
              if (txn_len > L_MAX) begin
                do_stall = 1'b1;
              end else if (flg[F_OUT]) begin
                hs = HS_NAK;
              end else begin
                hs          = HS_ACK;
                fset[F_OUT] = 1'b1;
              end
            end else begin
              do_abort = 1'b1;
            end
          end
          default: begin
            if (cur.swait) begin
              if (cur.stat_in) begin
                if (is_in) begin
                  hs        = HS_DATA;
                  nxt.swait = 1'b0;
                  nxt.dend  = 1'b0;
                end else begin
                  do_stall = 1'b1;
                end
              end else begin
                if (is_out && txn_len == '0) begin
                  hs        = HS_ACK;
                  nxt.swait = 1'b0;
                  nxt.dend  = 1'b0;
                end else begin
                  do_stall = 1'b1;
                end
              end
            end else begin
              hs = HS_NAK;
            end
          end
        endcase
      end

      if (do_stall) begin
        hs          = HS_STALL;
        fset[F_STL] = 1'b1;
        nxt         = to_idle(cur);
      end
      if (do_abort) begin
        fset[F_SUE] = 1'b1;
        nxt         = to_idle(cur);
      end
    end else if (host_ack) begin
      if (cur.st == EP_TX && cur.in_pend) begin
        nxt.in_pend = 1'b0;
        nxt.in_rdy  = 1'b0;
        fset[F_INS] = 1'b1;
        if (cur.dend) begin
          nxt.st      = EP_IDLE;
          nxt.swait   = 1'b1;
          nxt.stat_in = 1'b0;
        end
      end
    end else begin
      if (fw_data_end) nxt.dend = 1'b1;
      if (fw_clr_rdy && flg[F_OUT]) begin
        fclr[F_OUT] = 1'b1;
        if (cur.st == EP_IDLE && !cur.swait) begin
          if (de_eff) begin
            nxt.swait   = 1'b1;
            nxt.stat_in = 1'b1;
          end else begin
            nxt.st = cur.dir_in ? EP_TX : EP_RX;
          end
        end else if (cur.st == EP_RX && de_eff) begin
          nxt.st      = EP_IDLE;
          nxt.swait   = 1'b1;
          nxt.stat_in = 1'b1;
        end
      end
      if (fw_in_rdy && cur.st == EP_TX && !cur.in_rdy) nxt.in_rdy = 1'b1;
      if (fw_send_stall) nxt.sreq = 1'b1;
      if (fw_clr_stall) begin
        fclr[F_STL] = 1'b1;
        nxt.sreq    = 1'b0;
        if (flg[F_STL]) nxt = to_idle(nxt);
      end
      if (fw_clr_setup_end) fclr[F_SUE] = 1'b1;
      if (fw_clr_in_sent)   fclr[F_INS] = 1'b1;
    end
  end
endmodule

// File: rtl/usb_ctl_ep_seq.sv
module usb_ctl_ep_seq
  import ep0_pkg::*;
#(
  parameter int LEN_W     = 7,
  parameter int SETUP_LEN = 8,
  parameter int MAX_PKT   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_en,
  input  logic             txn_valid,
  input  logic [1:0]       txn_tok,
  input  logic [LEN_W-1:0] txn_len,
  input  logic             setup_dir_in,
  input  logic             host_ack,
  input  logic             fw_clr_rdy,
  input  logic             fw_data_end,
  input  logic             fw_in_rdy,
  input  logic             fw_send_stall,
  input  logic             fw_clr_stall,
  input  logic             fw_clr_setup_end,
  input  logic             fw_clr_in_sent,
  output logic [2:0]       hs_code,
  output logic [1:0]       ep_state,
  output logic             out_rdy,
  output logic             in_rdy,
  output logic             in_sent,
  output logic             sent_stall,
  output logic             setup_end,
  output logic             data_end,
  output logic             irq
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  ctx_t             ctx_q, ctx_d;
  hs_e              hs_q, hs_d;
  logic [NFLAG-1:0] flg, fset, fclr;
  logic             ctx_en;

  ep0_decide #(
    .LEN_W     (LEN_W),
    .SETUP_LEN (SETUP_LEN),
    .MAX_PKT   (MAX_PKT)
  ) u_decide (
    .cur              (ctx_q),
    .flg              (flg),
    .txn_valid        (txn_valid),
    .txn_tok          (txn_tok),
    .txn_len          (txn_len),
    .setup_dir_in     (setup_dir_in),
    .host_ack         (host_ack),
    .fw_clr_rdy       (fw_clr_rdy),
    .fw_data_end      (fw_data_end),
    .fw_in_rdy        (fw_in_rdy),
    .fw_send_stall    (fw_send_stall),
    .fw_clr_stall     (fw_clr_stall),
    .fw_clr_setup_end (fw_clr_setup_end),
    .fw_clr_in_sent   (fw_clr_in_sent),
    .nxt              (ctx_d),
    .fset             (fset),
    .fclr             (fclr),
    .hs               (hs_d)
  );

  assign ctx_en = txn_valid | host_ack | fw_clr_rdy | fw_data_end | fw_in_rdy
                | fw_send_stall | fw_clr_stall;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    ctx_q <= '0;
    else if (ctx_en) ctx_q <= ctx_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) hs_q <= HS_NONE;
    else          hs_q <= hs_d;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    ep0_flag u_flag (
      .clk   (clk),
      .rst_n (rst_s_n),
      .set   (fset[g]),
      .clr   (fclr[g]),
      .q     (flg[g])
    );
  end

  assign hs_code    = hs_q;
  assign ep_state   = ctx_q.st;
  assign in_rdy     = ctx_q.in_rdy;
  assign data_end   = ctx_q.dend;
  assign out_rdy    = flg[F_OUT];
  assign in_sent    = flg[F_INS];
  assign sent_stall = flg[F_STL];
  assign setup_end  = flg[F_SUE];
  assign irq        = irq_en & (|flg);
endmodule

// File: rtl/ep0_chk.sv
module ep0_chk #(
  parameter int LEN_W     = 7,
  parameter int SETUP_LEN = 8,
  parameter int MAX_PKT   = 32
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic             irq_en,
  input logic             txn_valid,
  input logic [1:0]       txn_tok,
  input logic [LEN_W-1:0] txn_len,
  input logic             host_ack,
  input logic             fw_clr_stall,
  input logic             fw_clr_setup_end,
  input logic [2:0]       hs_code,
  input logic [1:0]       ep_state,
  input logic             out_rdy,
  input logic             in_rdy,
  input logic             sent_stall,
  input logic             setup_end,
  input logic             irq,
  input logic             sreq
);
  localparam logic [LEN_W-1:0] L_SETUP = LEN_W'(SETUP_LEN);
  localparam logic [LEN_W-1:0] L_MAX   = LEN_W'(MAX_PKT);

  AST_SETUP_REJECT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (txn_valid && txn_tok == 2'd0 && txn_len != L_SETUP) |=> hs_code == 3'd0); // R2

  AST_SETUP_TAKEN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (txn_valid && txn_tok == 2'd0 && txn_len == L_SETUP)
      |=> (hs_code == 3'd1 && out_rdy && ep_state == 2'd0)); // R10

  AST_RX_OVERSIZE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ep_state == 2'd2 && txn_valid && txn_tok == 2'd2 && txn_len > L_MAX)
      |=> (hs_code == 3'd3 && sent_stall)); // R5

  AST_TX_EMPTY_NAK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ep_state == 2'd1 && txn_valid && txn_tok == 2'd1 && !in_rdy && !sreq)
      |=> hs_code == 3'd2); // R4

  AST_STALL_REQ: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sreq && txn_valid && txn_tok != 2'd0)
      |=> (hs_code == 3'd3 && sent_stall && ep_state == 2'd0)); // R7

  AST_UNEXP_TX: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ep_state == 2'd1 && txn_valid && txn_tok == 2'd2 && !sreq)
      |=> (setup_end && ep_state == 2'd0)); // R8

  AST_SUE_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (setup_end && !fw_clr_setup_end) |=> setup_end); // R8

  AST_CLR_STALL: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sent_stall && fw_clr_stall && !txn_valid && !host_ack)
      |=> (!sent_stall && ep_state == 2'd0)); // R9

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !irq_en |-> !irq); // R11

  AST_IRQ_STALL: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq_en && sent_stall) |-> irq); // R11
endmodule

bind usb_ctl_ep_seq ep0_chk #(
  .LEN_W     (LEN_W),
  .SETUP_LEN (SETUP_LEN),
  .MAX_PKT   (MAX_PKT)
) u_chk (
  .clk              (clk),
  .rst_s_n          (rst_s_n),
  .irq_en           (irq_en),
  .txn_valid        (txn_valid),
  .txn_tok          (txn_tok),
  .txn_len          (txn_len),
  .host_ack         (host_ack),
  .fw_clr_stall     (fw_clr_stall),
  .fw_clr_setup_end (fw_clr_setup_end),
  .hs_code          (hs_code),
  .ep_state         (ep_state),
  .out_rdy          (out_rdy),
  .in_rdy           (in_rdy),
  .sent_stall       (sent_stall),
  .setup_end        (setup_end),
  .irq              (irq),
  .sreq             (ctx_q.sreq)
);

// File: tb/usb_ctl_ep_seq_test.sv
`timescale 1ns/1ps
module usb_ctl_ep_seq_test;
  localparam int LEN_W = 7;

  localparam logic [1:0] T_SETUP = 2'd0;
  localparam logic [1:0] T_IN    = 2'd1;
  localparam logic [1:0] T_OUT   = 2'd2;

  // firmware command bits for the fw task
  localparam logic [6:0] C_CLR_RDY  = 7'h01;
  localparam logic [6:0] C_DEND     = 7'h02;
  localparam logic [6:0] C_IN_RDY   = 7'h04;
  localparam logic [6:0] C_SSTALL   = 7'h08;
  localparam logic [6:0] C_CLR_STL  = 7'h10;
  localparam logic [6:0] C_CLR_SUE  = 7'h20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             irq_en = 1'b0;
  logic             txn_valid = 1'b0;
  logic [1:0]       txn_tok = '0;
  logic [LEN_W-1:0] txn_len = '0;
  logic             setup_dir_in = 1'b0;
  logic             host_ack = 1'b0;
  logic [6:0]       cmd = '0;
  logic [2:0]       hs_code;
  logic [1:0]       ep_state;
  logic             out_rdy, in_rdy, in_sent, sent_stall, setup_end, data_end, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_ctl_ep_seq uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .irq_en           (irq_en),
    .txn_valid        (txn_valid),
    .txn_tok          (txn_tok),
    .txn_len          (txn_len),
    .setup_dir_in     (setup_dir_in),
    .host_ack         (host_ack),
    .fw_clr_rdy       (cmd[0]),
    .fw_data_end      (cmd[1]),
    .fw_in_rdy        (cmd[2]),
    .fw_send_stall    (cmd[3]),
    .fw_clr_stall     (cmd[4]),
    .fw_clr_setup_end (cmd[5]),
    .fw_clr_in_sent   (cmd[6]),
    .hs_code          (hs_code),
    .ep_state         (ep_state),
    .out_rdy          (out_rdy),
    .in_rdy           (in_rdy),
    .in_sent          (in_sent),
    .sent_stall       (sent_stall),
    .setup_end        (setup_end),
    .data_end         (data_end),
    .irq              (irq)
  );

  function automatic int exp_setup_hs(input int len);
    return (len == 8) ? 1 : 0;
  endfunction

  function automatic int exp_rx_hs(input int len);
    return (len > 32) ? 3 : 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next one, results visible
  task automatic txn(input logic [1:0] t, input int l, input bit d);
    txn_valid = 1'b1; txn_tok = t; txn_len = LEN_W'(l); setup_dir_in = d;
    @(negedge clk);
    txn_valid = 1'b0; txn_len = '0;
  endtask

  task automatic fw(input logic [6:0] c);
    cmd = c;
    @(negedge clk);
    cmd = '0;
  endtask

  task automatic ack();
    host_ack = 1'b1;
    @(negedge clk);
    host_ack = 1'b0;
  endtask

  task automatic start(input bit d);
    txn(T_SETUP, 8, d);
    fw(C_CLR_RDY);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d0c_5a17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 state", ep_state, 0);
    chk("R1 hs", hs_code, 0);
    chk("R1 flags", {out_rdy, in_rdy, in_sent, sent_stall, setup_end, data_end, irq}, 0);

    // R6 idle with nothing pending
    txn(T_IN, 0, 0);
    chk("R6 idle IN nak", hs_code, 2);

    // R2 setup length
    txn(T_SETUP, 7, 1);
    chk("R2 short setup hs", hs_code, 0);
    chk("R2 short setup out_rdy", out_rdy, 0);
    irq_en = 1'b1;
    txn(T_SETUP, 8, 1);
    chk("R2 setup ack", hs_code, 1);
    chk("R2 setup out_rdy", out_rdy, 1);
    chk("R11 irq on out_rdy", irq, 1);

    // R3 into TX
    fw(C_CLR_RDY);
    chk("R3 to TX", ep_state, 1);
    chk("R3 out_rdy cleared", out_rdy, 0);
    chk("R11 irq idle", irq, 0);

    // R4 TX behaviour
    txn(T_IN, 0, 0);
    chk("R4 empty nak", hs_code, 2);
    fw(C_IN_RDY);
    chk("R4 in_rdy", in_rdy, 1);
    txn(T_IN, 0, 0);
    chk("R4 data", hs_code, 4);
    ack();
    chk("R4 ack clears in_rdy", in_rdy, 0);
    chk("R4 in_sent", in_sent, 1);
    chk("R4 still TX", ep_state, 1);
    fw(7'h40);
    chk("R4 in_sent cleared", in_sent, 0);
    fw(C_IN_RDY | C_DEND);
    txn(T_IN, 0, 0);
    ack();
    chk("R4 last ack to idle", ep_state, 0);

    // R6 IN after IN stage closed
    txn(T_IN, 0, 0);
    chk("R6 extra IN stall", hs_code, 3);
    chk("R6 sent_stall", sent_stall, 1);
    chk("R11 irq on stall", irq, 1);
    fw(C_CLR_STL);
    chk("R9 stall cleared", sent_stall, 0);
    chk("R9 idle", ep_state, 0);

    // R6 good and bad OUT status after IN stage
    start(1);
    fw(C_IN_RDY | C_DEND);
    txn(T_IN, 0, 0);
    ack();
    chk("R6 data_end held", data_end, 1);
    txn(T_OUT, 0, 0);
    chk("R6 empty status ack", hs_code, 1);
    chk("R6 data_end cleared", data_end, 0);
    start(1);
    fw(C_IN_RDY | C_DEND);
    txn(T_IN, 0, 0);
    ack();
    txn(T_OUT, 3, 0);
    chk("R6 nonempty status stall", hs_code, 3);
    fw(C_CLR_STL);

    // R3 / R5 OUT stage
    start(0);
    chk("R3 to RX", ep_state, 2);
    txn(T_OUT, 40, 0);
    chk("R5 oversize stall", hs_code, 3);
    chk("R5 oversize flag", sent_stall, 1);
    fw(C_CLR_STL);
    start(0);
    txn(T_OUT, 32, 0);
    chk("R5 max size ack", hs_code, 1);
    chk("R5 out_rdy", out_rdy, 1);
    txn(T_OUT, 5, 0);
    chk("R5 busy nak", hs_code, 2);
    fw(C_CLR_RDY | C_DEND);
    chk("R3 RX closed idle", ep_state, 0);
    chk("R3 data_end", data_end, 1);
    txn(T_OUT, 0, 0);
    chk("R6 extra OUT stall", hs_code, 3);
    fw(C_CLR_STL);

    // R6 IN status after OUT stage
    start(0);
    txn(T_OUT, 0, 0);
    fw(C_CLR_RDY | C_DEND);
    txn(T_IN, 0, 0);
    chk("R6 in status data", hs_code, 4);
    chk("R6 status done", data_end, 0);

    // R3 no data stage
    txn(T_SETUP, 8, 1);
    fw(C_CLR_RDY | C_DEND);
    chk("R3 no data stays idle", ep_state, 0);
    txn(T_IN, 0, 0);
    chk("R6 no data status", hs_code, 4);

    // R7 firmware stall
    start(0);
    fw(C_SSTALL);
    txn(T_OUT, 4, 0);
    chk("R7 stall hs", hs_code, 3);
    chk("R7 stall flag", sent_stall, 1);
    chk("R7 idle", ep_state, 0);
    fw(C_CLR_STL);
    // R9 cancel pending request
    start(0);
    fw(C_SSTALL);
    fw(C_CLR_STL);
    txn(T_OUT, 4, 0);
    chk("R9 cancelled request", hs_code, 1);
    chk("R9 still no stall", sent_stall, 0);

    // R8 unexpected token
    start(1);
    txn(T_OUT, 0, 0);
    chk("R8 no handshake", hs_code, 0);
    chk("R8 setup_end", setup_end, 1);
    chk("R8 idle", ep_state, 0);
    repeat (3) @(negedge clk);
    chk("R8 held", setup_end, 1);
    fw(C_CLR_SUE);
    chk("R8 cleared", setup_end, 0);

    // R10 setup overrides RX with a stall request pending
    start(0);
    fw(C_SSTALL);
    txn(T_SETUP, 8, 0);
    chk("R10 ack", hs_code, 1);
    chk("R10 setup_end", setup_end, 1);
    chk("R10 idle", ep_state, 0);
    chk("R10 out_rdy", out_rdy, 1);
    fw(C_CLR_SUE);
    fw(C_CLR_RDY);
    txn(T_OUT, 1, 0);
    chk("R10 stall request dropped", hs_code, 1);

    // R11 enable gating
    irq_en = 1'b0;
    #1;
    chk("R11 gated", irq, 0);
    irq_en = 1'b1;
    #1;
    chk("R11 enabled", irq, 1);

    // random lengths
    for (int i = 0; i < 150; i++) begin
      int l1, l2;
      l1 = $urandom_range(15);
      txn(T_SETUP, l1, 0);
      chk("R2 random setup", hs_code, exp_setup_hs(l1));
      txn(T_SETUP, 8, 0);
      fw(C_CLR_RDY);
      l2 = $urandom_range(63);
      txn(T_OUT, l2, 0);
      chk("R5 random out", hs_code, exp_rx_hs(l2));
      if (l2 > 32) begin
        fw(C_CLR_STL);
      end else begin
        fw(C_CLR_RDY | C_DEND);
        txn(T_IN, 0, 0);
        chk("R6 random status", hs_code, 4);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule